// File: doc/BRIEF.md
# Register-Mapped Two-Wire Sensor Control Bridge

This block lets a host program an image sensor's internal registers over a two-wire serial control bus (the SCCB/I2C family). The host sees a small bank of byte registers. It loads the sensor's bus address, a register index and, for a write, a data value. It then writes an operation code, and the block runs the whole bus transaction by itself. The host polls a status register that stays zero while the block works. When the transaction ends, the register shows a per-direction success code or a failure code.

A register write is sent as one frame: the device address, then the index, then the value. A register read is sent as two frames. The first frame carries the device address and the index and ends with a stop. The second frame starts again with the address in read form and takes in one byte, which the master answers with a NACK. That byte is then held in a readable register. The bit engine counts quarter-bit phases from a divided system clock. It drives both lines as open-drain pull-downs and brings the SDA line in through a synchronizer. A separate enable register has to hold a value other than 0x00 and 0x01 before any transaction may start.

Top module: `sccb_bridge`

## Requirements
- R1: After reset, status (offset 1) reads 0x00, enable (offset 2) reads 0x00, device address (offset 3) reads 0x60, and neither line is pulled low.
- R2: Offsets 2, 3, 4 (write index), 5 (write value) and 8 (read index) read back the last byte written to them; read data appears one clock after the address is presented. Host writes to offset 9 (read result) leave it unchanged.
- R3: Writing 0x05 to offset 0 sends START, the device address with bit 0 forced to 0, the write index, the write value and STOP; on success the status becomes 0x04.
- R4: Writing 0x70 to offset 0 sends START, device address (bit 0 = 0), read index, STOP, then START, device address with bit 0 = 1, takes in one byte MSB first, answers it with NACK and sends STOP; on success the status becomes 0x01 and the byte reads back at offset 9.
- R5: An accepted operation clears the status to 0x00 at once, and the status stays 0x00 until the transaction ends.
- R6: If the slave leaves SDA high in the acknowledge slot of any byte the master sends, the block sends STOP, ends the transaction with status 0x80, releases both lines and leaves offset 9 unchanged.
- R7: While the enable register holds 0x00 or 0x01, operation writes are ignored: no START appears and the status keeps its value. Any other enable value allows transactions.
- R8: Operation writes that arrive while a transaction is in progress are ignored; the running transaction completes with its own result.
- R9: Values other than 0x05 and 0x70 written to offset 0 are ignored.
- R10: SDA changes while SCL is high only for START (falling) and STOP (rising): one of each per write, two of each per read.
- R11: During data bits, SCL stays high for 2*QTR_CYCLES clocks, within a bit period of 4*QTR_CYCLES clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for the addressed register |
| host_addr | input | 4 | Register offset within the bank |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data for host_addr, valid one clock later |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it to the pull-up |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it to the pull-up |

## Verification
If the step sequencer holds a wrong state, the bus shows it within one quarter-bit phase. The result is a missing or extra START or STOP, a shifted byte landing at the wrong sensor index, or an SDA edge while SCL is high that the slave model counts as a spurious condition. Errors in the acknowledge sampling or in abort handling show up only at the end of the transaction, as a wrong status code or a read byte that is stale or corrupt. A wrong busy or enable state in the register bank shows up on the next operation write: a START that should not happen, one that never comes, or a status that is not cleared.

// File: rtl/sccb_pkg.sv
package sccb_pkg;

  // Register offsets; host software decodes these positions
  localparam logic [3:0] OFS_OP    = 4'd0;
  localparam logic [3:0] OFS_STAT  = 4'd1;
  localparam logic [3:0] OFS_EN    = 4'd2;
  localparam logic [3:0] OFS_DEV   = 4'd3;
  localparam logic [3:0] OFS_WIDX  = 4'd4;
  localparam logic [3:0] OFS_WVAL  = 4'd5;
  localparam logic [3:0] OFS_RIDX  = 4'd8;
  localparam logic [3:0] OFS_RVAL  = 4'd9;

  localparam logic [7:0] OPC_WR    = 8'h05;
  localparam logic [7:0] OPC_RD    = 8'h70;

  localparam logic [7:0] STS_WR_OK = 8'h04;
  localparam logic [7:0] STS_RD_OK = 8'h01;
  localparam logic [7:0] STS_NACK  = 8'h80;

  typedef enum logic [2:0] {
    K_START, K_TX, K_RX, K_STOP, K_END
  } step_kind_t;

  // Step list of a transaction: write is one frame, read is two frames
  function automatic step_kind_t step_of(input logic rd, input logic [3:0] seg);
    step_kind_t k;
    k = K_END;
    if (!rd) begin
      case (seg)
        4'd0:                k = K_START;
        4'd1, 4'd2, 4'd3:    k = K_TX;
        4'd4:                k = K_STOP;
        default:             k = K_END;
      endcase
    end else begin
      case (seg)
        4'd0, 4'd4:          k = K_START;
        4'd1, 4'd2, 4'd5:    k = K_TX;
        4'd6:                k = K_RX;
        4'd3, 4'd7:          k = K_STOP;
        default:             k = K_END;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/sccb_qtick.sv
module sccb_qtick #(
  parameter int QTR_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(QTR_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)     cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/sccb_sync.sv
module sccb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] st;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[0] <= 1'b1;
        else     st[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[i] <= 1'b1;
        else     st[i] <= st[i-1];
      end
    end
  end

  assign dout = st[STAGES-1];
endmodule

// File: rtl/sccb_engine.sv
module sccb_engine
  import sccb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       start,
  input  logic       op_read,
  input  logic [6:0] dev7,
  input  logic [7:0] widx,
  input  logic [7:0] wval,
  input  logic [7:0] ridx,
  input  logic       sda_s,
  output logic       busy,
  output logic       done,
  output logic       nack,
  output logic [7:0] rx_byte,
  output logic       scl_lo,
  output logic       sda_lo,
  output logic       bit_phase
);
  step_kind_t kind;
  logic [3:0] seg;
  logic [1:0] q;
  logic [3:0] bidx;
  logic       rd, abort;
  logic [6:0] dev_l;
  logic [7:0] widx_l, wval_l, ridx_l, cur;
  logic [3:0] stop_seg;

  assign kind      = step_of(rd, seg);
  assign bit_phase = busy && (kind == K_TX || kind == K_RX);
  assign stop_seg  = rd ? ((seg < 4'd3) ? 4'd3 : 4'd7) : 4'd4;

  always_comb begin
    case (seg)
      4'd1:    cur = {dev_l, 1'b0};
      4'd2:    cur = rd ? ridx_l : widx_l;
      4'd3:    cur = wval_l;
      4'd5:    cur = {dev_l, 1'b1};
      default: cur = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;  done <= 1'b0;  nack <= 1'b0;
      seg <= '0;  q <= '0;  bidx <= '0;  rd <= 1'b0;  abort <= 1'b0;
      dev_l <= '0;  widx_l <= '0;  wval_l <= '0;  ridx_l <= '0;
      rx_byte <= '0;  scl_lo <= 1'b0;  sda_lo <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;  seg <= '0;  q <= '0;  bidx <= '0;  abort <= 1'b0;
          rd <= op_read;  dev_l <= dev7;
          widx_l <= widx;  wval_l <= wval;  ridx_l <= ridx;
        end
      end else if (tick) begin
        q <= q + 2'd1;
        case (kind)
          K_START: begin
            if (q == 2'd1) sda_lo <= 1'b1;       // falling SDA, SCL high
            if (q == 2'd3) scl_lo <= 1'b1;
          end
          K_TX, K_RX: begin
            case (q)
              2'd0: sda_lo <= (kind == K_TX) && !bidx[3] && !cur[~bidx[2:0]];
              2'd1: scl_lo <= 1'b0;
              2'd2: begin
                if (!bidx[3]) begin
                  if (kind == K_RX) rx_byte <= {rx_byte[6:0], sda_s};
                end else if (kind == K_TX && sda_s) begin
                  abort <= 1'b1;
                end
              end
              default: scl_lo <= 1'b1;
            endcase
          end
          K_STOP: begin
            if (q == 2'd0) sda_lo <= 1'b1;
            if (q == 2'd1) scl_lo <= 1'b0;
            if (q == 2'd2) sda_lo <= 1'b0;       // rising SDA, SCL high
          end
          default: ;
        endcase
        if (q == 2'd3) begin
          case (kind)
            K_TX, K_RX: begin
              if (bidx == 4'd8) begin
                bidx <= '0;
                seg  <= abort ? stop_seg : seg + 4'd1;
              end else begin
                bidx <= bidx + 4'd1;
              end
            end
            K_STOP: begin
              if (abort || step_of(rd, seg + 4'd1) == K_END) begin
                busy <= 1'b0;  done <= 1'b1;  nack <= abort;
              end else begin
                seg <= seg + 4'd1;
              end
            end
            default: seg <= seg + 4'd1;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sccb_regs.sv
module sccb_regs
  import sccb_pkg::*;
#(
  parameter logic [7:0] DEFAULT_DEV = 8'h60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_we,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       eng_done,
  input  logic       eng_nack,
  input  logic [7:0] eng_rx,
  output logic       start,
  output logic       op_read,
  output logic [6:0] dev7,
  output logic [7:0] widx,
  output logic [7:0] wval,
  output logic [7:0] ridx,
  output logic       pend,
  output logic       bus_en,
  output logic [7:0] status
);
  logic [7:0] en_q, dev_q, rval_q;
  logic       op_hit, opc_ok;

  assign bus_en = (en_q[7:1] != 7'd0);
  assign op_hit = host_we && (host_addr == OFS_OP);
  assign opc_ok = (host_wdata == OPC_WR) || (host_wdata == OPC_RD);
  assign dev7   = dev_q[7:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;  dev_q <= DEFAULT_DEV;  widx <= '0;  wval <= '0;  ridx <= '0;
      rval_q <= '0;  status <= '0;  pend <= 1'b0;  start <= 1'b0;  op_read <= 1'b0;
      host_rdata <= '0;
    end else begin
      start <= 1'b0;
      if (host_we) begin
        case (host_addr)
          OFS_EN:   en_q  <= host_wdata;
          OFS_DEV:  dev_q <= host_wdata;
          OFS_WIDX: widx  <= host_wdata;
          OFS_WVAL: wval  <= host_wdata;
          OFS_RIDX: ridx  <= host_wdata;
          default: ;
        endcase
      end
      if (op_hit && opc_ok && bus_en && !pend) begin
        start   <= 1'b1;
        op_read <= (host_wdata == OPC_RD);
        status  <= '0;
        pend    <= 1'b1;
      end else if (eng_done) begin
        pend   <= 1'b0;
        status <= eng_nack ? STS_NACK : (op_read ? STS_RD_OK : STS_WR_OK);
        if (!eng_nack && op_read) rval_q <= eng_rx;
      end
      case (host_addr)
        OFS_STAT: host_rdata <= status;
        OFS_EN:   host_rdata <= en_q;
        OFS_DEV:  host_rdata <= dev_q;
        OFS_WIDX: host_rdata <= widx;
        OFS_WVAL: host_rdata <= wval;
        OFS_RIDX: host_rdata <= ridx;
        OFS_RVAL: host_rdata <= rval_q;
        default:  host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sccb_bridge.sv
module sccb_bridge #(
  parameter int         QTR_CYCLES  = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DEFAULT_DEV = 8'h60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_we,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       sda_drive_low
);
  logic       start, op_read, pend, bus_en;
  logic [6:0] dev7;
  logic [7:0] widx, wval, ridx, status, rx_byte;
  logic       eng_busy, eng_done, eng_nack, tick, sda_s, bit_phase;

  sccb_regs #(.DEFAULT_DEV(DEFAULT_DEV)) i_regs (
    .clk, .rst, .host_we, .host_addr, .host_wdata, .host_rdata,
    .eng_done, .eng_nack, .eng_rx(rx_byte),
    .start, .op_read, .dev7, .widx, .wval, .ridx, .pend, .bus_en, .status
  );

  sccb_qtick #(.QTR_CYCLES(QTR_CYCLES)) i_tick (
    .clk, .rst, .run(eng_busy), .tick
  );

  sccb_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk, .rst, .din(sda_in), .dout(sda_s)
  );

  sccb_engine i_engine (
    .clk, .rst, .tick, .start, .op_read, .dev7, .widx, .wval, .ridx, .sda_s,
    .busy(eng_busy), .done(eng_done), .nack(eng_nack), .rx_byte,
    .scl_lo(scl_drive_low), .sda_lo(sda_drive_low), .bit_phase
  );
endmodule

// File: rtl/sccb_bridge_chk.sv
module sccb_bridge_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_lo,
  input logic       sda_lo,
  input logic       eng_busy,
  input logic       eng_done,
  input logic       bit_phase,
  input logic       pend,
  input logic       bus_en,
  input logic [7:0] status
);
  AST_IDLE_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |-> (!scl_lo && !sda_lo)); // R6

  AST_STATUS_ZERO_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    pend |-> (status == 8'h00)); // R5

  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!bus_en && !pend) |=> !pend); // R7

  AST_ENGINE_ONLY_WHEN_PENDING: assert property (@(posedge clk) disable iff (rst)
    eng_busy |-> pend); // R8

  AST_DONE_GIVES_CODE: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> (status == 8'h04 || status == 8'h01 || status == 8'h80)); // R3

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (bit_phase && $past(bit_phase) && !scl_lo && !$past(scl_lo)) |-> $stable(sda_lo)); // R10
endmodule

bind sccb_bridge sccb_bridge_chk i_chk (
  .clk(clk), .rst(rst), .scl_lo(scl_drive_low), .sda_lo(sda_drive_low),
  .eng_busy(eng_busy), .eng_done(eng_done), .bit_phase(bit_phase),
  .pend(pend), .bus_en(bus_en), .status(status)
);

// File: tb/test_sccb_bridge.sv
module test_sccb_bridge;
  localparam int QTR = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_we = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       scl_lo, sda_lo;
  logic       slv_lo = 1'b0;
  wire        scl_line = ~scl_lo;
  wire        sda_line = ~(sda_lo | slv_lo);

  always #5 clk = ~clk;

  sccb_bridge #(.QTR_CYCLES(QTR)) i_sccb_bridge (
    .clk, .rst, .host_we, .host_addr, .host_wdata, .host_rdata,
    .sda_in(sda_line), .scl_drive_low(scl_lo), .sda_drive_low(sda_lo)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- slave model (device address 0x30, 7-bit) ----------------
  logic [7:0] mem [256];
  int   nstarts = 0, nstops = 0, nwr = 0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic active = 1'b0, addressed = 1'b0, rw = 1'b0, tx_mode = 1'b0, mnack = 1'b0;
  int   bitcnt = 0, bytecnt = 0;
  logic [7:0] shreg = '0, ptr = '0;

  always @(scl_line or sda_line) begin
    if (scl_line && p_scl) begin
      if (!sda_line && p_sda) begin
        nstarts++; active = 1'b1; bitcnt = 0; bytecnt = 0;
        tx_mode = 1'b0; mnack = 1'b0; slv_lo = 1'b0;
      end else if (sda_line && !p_sda) begin
        nstops++; active = 1'b0; slv_lo = 1'b0;
      end
    end else if (scl_line && !p_scl) begin
      if (active) begin
        if (bitcnt < 8) shreg = {shreg[6:0], sda_line};
        else if (tx_mode) mnack = sda_line;
        bitcnt++;
      end
    end else if (!scl_line && p_scl) begin
      if (active) begin
        if (bitcnt == 8) begin
          if (!tx_mode) begin
            if (bytecnt == 0) begin
              addressed = (shreg[7:1] == 7'h30);
              rw = shreg[0];
              slv_lo = addressed;
            end else if (addressed) begin
              if (bytecnt == 1) ptr = shreg;
              else begin mem[ptr] = shreg; ptr++; nwr++; end
              slv_lo = 1'b1;
            end
          end else begin
            slv_lo = 1'b0;
          end
        end else if (bitcnt == 9) begin
          bitcnt = 0; bytecnt++; slv_lo = 1'b0;
          tx_mode = addressed && rw && !mnack;
          if (tx_mode) slv_lo = !mem[ptr][7];
        end else if (tx_mode && bitcnt >= 1 && bitcnt < 8) begin
          slv_lo = !mem[ptr][7-bitcnt];
        end
      end
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  // ---------------- host access ----------------
  task automatic host_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic wait_status(output logic [7:0] s);
    s = 8'h00;
    for (int i = 0; i < 3000; i++) begin
      host_read(4'd1, s);
      if (s != 8'h00) break;
    end
  endtask

  function automatic logic [7:0] preset(input int i);
    return 8'(i * 7 + 3);
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [7:0] v;
    check("R1 scl released", {31'd0, scl_line}, 32'd1);
    check("R1 sda released", {31'd0, sda_line}, 32'd1);
    host_read(4'd1, v); check("R1 status", v, 8'h00);
    host_read(4'd2, v); check("R1 enable", v, 8'h00);
    host_read(4'd3, v); check("R1 device address", v, 8'h60);
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    host_write(4'd2, 8'h1E); host_write(4'd4, 8'hAB);
    host_write(4'd5, 8'h12); host_write(4'd8, 8'h34);
    host_write(4'd9, 8'h77);
    host_read(4'd2, v); check("R2 enable readback", v, 8'h1E);
    host_read(4'd3, v); check("R2 device readback", v, 8'h60);
    host_read(4'd4, v); check("R2 write index readback", v, 8'hAB);
    host_read(4'd5, v); check("R2 write value readback", v, 8'h12);
    host_read(4'd8, v); check("R2 read index readback", v, 8'h34);
    host_read(4'd9, v); check("R2 read result not host writable", v, 8'h00);
  endtask

  task automatic t_write();
    logic [7:0] s;
    int st0, sp0, w0, n;
    st0 = nstarts; sp0 = nstops; w0 = nwr;
    host_write(4'd4, 8'h3C); host_write(4'd5, 8'hC4);
    host_write(4'd0, 8'h05);
    @(negedge scl_line); @(posedge scl_line);
    n = 0;
    while (scl_line) begin
      @(negedge clk);
      if (scl_line) n++;
    end
    check("R11 SCL high phase", n, 2 * QTR);
    wait_status(s);
    check("R3 write status", s, 8'h04);
    check("R3 sensor register written", mem[8'h3C], 8'hC4);
    check("R3 one data byte stored", nwr - w0, 1);
    check("R10 write starts", nstarts - st0, 1);
    check("R10 write stops", nstops - sp0, 1);
  endtask

  task automatic t_read();
    logic [7:0] s, v;
    int st0, sp0;
    st0 = nstarts; sp0 = nstops;
    host_write(4'd8, 8'h1D);
    host_write(4'd0, 8'h70);
    host_read(4'd1, s); check("R5 status cleared on accept", s, 8'h00);
    wait_status(s);
    check("R4 read status", s, 8'h01);
    host_read(4'd9, v); check("R4 read byte", v, preset(8'h1D));
    check("R4 master NACK on read byte", {31'd0, mnack}, 32'd1);
    check("R10 read starts", nstarts - st0, 2);
    check("R10 read stops", nstops - sp0, 2);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] s;
    int st0;
    st0 = nstarts;
    host_write(4'd4, 8'h10); host_write(4'd5, 8'h99);
    host_write(4'd0, 8'h05);
    repeat (20) @(negedge clk);
    host_write(4'd0, 8'h70);
    wait_status(s);
    check("R8 busy opcode ignored status", s, 8'h04);
    check("R8 single transaction", nstarts - st0, 1);
    check("R8 write still completed", mem[8'h10], 8'h99);
  endtask

  task automatic t_nack();
    logic [7:0] s, v;
    int st0;
    st0 = nstarts;
    host_write(4'd3, 8'h42);
    host_write(4'd0, 8'h70);
    wait_status(s);
    check("R6 NACK status", s, 8'h80);
    host_read(4'd9, v); check("R6 read result kept", v, preset(8'h1D));
    check("R6 aborted after one frame", nstarts - st0, 1);
    check("R6 lines released", {30'd0, scl_line, sda_line}, 32'd3);
    host_write(4'd3, 8'h60);
  endtask

  task automatic t_disabled();
    logic [7:0] s;
    int st0;
    st0 = nstarts;
    host_write(4'd2, 8'h01);
    host_write(4'd0, 8'h05);
    repeat (200) @(negedge clk);
    host_read(4'd1, s); check("R7 enable 0x01 status kept", s, 8'h80);
    host_write(4'd2, 8'h00);
    host_write(4'd0, 8'h70);
    repeat (200) @(negedge clk);
    host_read(4'd1, s); check("R7 enable 0x00 status kept", s, 8'h80);
    check("R7 no START while disabled", nstarts - st0, 0);
    host_write(4'd2, 8'h1E);
  endtask

  task automatic t_bad_opcode();
    logic [7:0] s;
    int st0;
    st0 = nstarts;
    host_write(4'd0, 8'h06);
    repeat (100) @(negedge clk);
    host_read(4'd1, s); check("R9 unknown opcode status kept", s, 8'h80);
    check("R9 unknown opcode no START", nstarts - st0, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = preset(i);
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_regmap();
    t_write();
    t_read();
    t_busy_ignore();
    t_nack();
    t_disabled();
    t_bad_opcode();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end
endmodule